// File: doc/BRIEF.md
# Asynchronous Exception Entry Controller

This block sits beside the issue stage of a simple 32-bit pipeline and turns two asynchronous requests into a clean redirect. The first request is a non-maskable interrupt pin. The second is a debug interrupt, raised either by an external request line or by a software-settable break bit. For each request the block computes the resume address and updates the status and debug state. It then issues a one-cycle redirect strobe with the vector the fetch unit must jump to.

The NMI pin is brought into the clock domain through a synchroniser. Only its rising edge is captured, into a pending flag. The flag is served only when the pipeline reports an instruction boundary. A debug interrupt needs no boundary and is taken on the first cycle it is requested while the core is not already in debug mode.

Every interface of the block is a plain control or status pin. There is no stream interface and no back-pressure. The fetch unit must accept a redirect in the cycle it is strobed.

Top module: `async_trap_entry`

## Requirements
- R1: The NMI pin is edge sensitive. Each low-to-high transition produces exactly one NMI entry, however long the pin then stays high.
- R2: A captured NMI edge stays pending until it is served. It is served only in a cycle where `boundary_i` is high, and `redirect_o` rises in the following cycle.
- R3: `status_o` packs the fields as bit 4 BEV, bit 3 TS, bit 2 SR, bit 1 NMI, bit 0 ERL. `stat_ld_i` loads `stat_d_i` when no entry occurs in that cycle. An NMI entry sets the fields to BEV=1, TS=0, SR=0, NMI=1 and ERL=1.
- R4: On NMI entry, `errpc_o` takes `pc_i` minus 4 when `in_delay_i` is high, and `pc_i` otherwise.
- R5: Every entry raises `redirect_o` for exactly one cycle. For an NMI, `target_o` is 0xBFC0_0000.
- R6: A debug interrupt is requested by `dbg_req_i` or by the break bit. A `brk_set_i` pulse sets the break bit, it is visible on `brk_o`, and it clears when its debug entry is taken.
- R7: A debug entry needs no instruction boundary. It sets `dint_o` and `dbg_mode_o`, and `target_o` is 0xBFC0_0480.
- R8: On debug entry, `dpc_o` takes `pc_i` minus 4 and `dbd_o` is 1 when `in_delay_i` is high. Otherwise `dpc_o` takes `pc_i` and `dbd_o` is 0.
- R9: When a debug request and an NMI are both eligible in the same cycle, the debug entry wins. The NMI stays pending and is taken at a later boundary.
- R10: No debug entry occurs while `dbg_mode_o` is high, and a pending break bit is held meanwhile. A `dret_i` pulse clears `dbg_mode_o` and `dint_o`.
- R11: An NMI entry leaves `dpc_o`, `dbd_o` and `dint_o` unchanged. A debug entry leaves `errpc_o` and `status_o` unchanged.
- R12: After reset, `redirect_o`, `dint_o`, `dbd_o`, `dbg_mode_o` and `brk_o` are 0, `errpc_o` and `dpc_o` are 0, and `status_o` is 5'b10001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| nmi_pin_i | input | 1 | Asynchronous non-maskable interrupt pin |
| dbg_req_i | input | 1 | External debug interrupt request (level) |
| brk_set_i | input | 1 | Pulse that sets the debug break bit |
| dret_i | input | 1 | Return from debug mode |
| boundary_i | input | 1 | Current cycle is an instruction boundary |
| pc_i | input | XLEN | PC of the instruction to be interrupted |
| in_delay_i | input | 1 | That instruction sits in a branch delay slot |
| stat_ld_i | input | 1 | Load status fields from the pipeline |
| stat_d_i | input | 5 | Status value to load (R3 layout) |
| redirect_o | output | 1 | One-cycle redirect strobe |
| target_o | output | XLEN | Vector for the redirect |
| status_o | output | 5 | Status fields (R3 layout) |
| errpc_o | output | XLEN | NMI return address |
| dpc_o | output | XLEN | Debug return address |
| dint_o | output | 1 | Debug-interrupt status bit |
| dbd_o | output | 1 | Debug delay-slot status bit |
| dbg_mode_o | output | 1 | Core is in debug mode |
| brk_o | output | 1 | Debug break bit |

## Verification
The NMI path is driven in three patterns, each separating a different failure:
- A pin held high across many boundaries separates edge capture from level sensing.
- An edge with no boundary for several cycles separates correct pending behaviour from eager or lost entries.
- A delay-slot entry separates the two resume-address rules.

Debug entry is tried from the request line and from the break bit, with the request held through debug mode and the break bit set while in debug mode, which exposes missing re-entry blocking. A pending NMI that meets a debug request at the same boundary shows whether priority is right and whether the losing NMI survives.

// File: rtl/async_trap_pkg.sv
package async_trap_pkg;

  typedef struct packed {
    logic bev;
    logic ts;
    logic sr;
    logic nmi;
    logic erl;
  } stat_t;

  localparam stat_t STAT_RST = '{bev: 1'b1, ts: 1'b0, sr: 1'b0, nmi: 1'b0, erl: 1'b1};
  localparam stat_t STAT_NMI = '{bev: 1'b1, ts: 1'b0, sr: 1'b0, nmi: 1'b1, erl: 1'b1};

  typedef enum logic [1:0] {
    ENTRY_NONE = 2'd0,
    ENTRY_NMI  = 2'd1,
    ENTRY_DBG  = 2'd2
  } entry_e;

endpackage

// File: rtl/trap_nmi_capture.sv
module trap_nmi_capture #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic clr_i,
  output logic pend_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   rise;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign rise = sync_q[LAST] & ~prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_q[LAST];
      pend_q <= rise | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;

  // R2: pending edge survives until served
  assert_pend_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);

  // R1: service consumes the edge
  assert_pend_consumed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise) |=> !pend_o);

endmodule

// File: rtl/trap_dbg_track.sv
module trap_dbg_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic brk_set_i,
  input  logic take_i,
  input  logic dret_i,
  output logic want_o,
  output logic mode_o,
  output logic brk_o,
  output logic dint_o
);
  logic brk_q, mode_q, dint_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      mode_q <= 1'b0;
      dint_q <= 1'b0;
    end else begin
      brk_q <= brk_set_i | (brk_q & ~take_i);
      if (take_i) begin
        mode_q <= 1'b1;
        dint_q <= 1'b1;
      end else if (dret_i) begin
        mode_q <= 1'b0;
        dint_q <= 1'b0;
      end
    end
  end

  assign want_o = (req_i | brk_q) & ~mode_q;
  assign mode_o = mode_q;
  assign brk_o  = brk_q;
  assign dint_o = dint_q;

  // R10: no entry while already in debug mode
  assert_no_reentry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !mode_o);

  // R7: entry raises mode and status bit
  assert_dint_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (mode_o && dint_o));

endmodule

// File: rtl/trap_return_calc.sv
module trap_return_calc #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_delay_i,
  output logic [XLEN-1:0] ret_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    if (in_delay_i) ret_o = pc_i - STEP;
    else            ret_o = pc_i;
  end
endmodule

// File: rtl/trap_entry_arb.sv
module trap_entry_arb
  import async_trap_pkg::*;
(
  input  logic   dbg_want_i,
  input  logic   nmi_pend_i,
  input  logic   boundary_i,
  output entry_e sel_o
);
  always_comb begin
    if (dbg_want_i)                   sel_o = ENTRY_DBG;
    else if (nmi_pend_i && boundary_i) sel_o = ENTRY_NMI;
    else                              sel_o = ENTRY_NONE;
  end
endmodule

// File: rtl/trap_entry_regs.sv
module trap_entry_regs
  import async_trap_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DEBUG_VEC  = 32'hBFC0_0480
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  entry_e          sel_i,
  input  logic [XLEN-1:0] ret_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_delay_i,
  input  logic            stat_ld_i,
  input  stat_t           stat_d_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output stat_t           status_o,
  output logic [XLEN-1:0] errpc_o,
  output logic [XLEN-1:0] dpc_o,
  output logic            dbd_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic            redir_q;
  logic [XLEN-1:0] tgt_q, errpc_q, dpc_q;
  stat_t           stat_q;
  logic            dbd_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      redir_q <= 1'b0;
      tgt_q   <= '0;
      errpc_q <= '0;
      dpc_q   <= '0;
      stat_q  <= STAT_RST;
      dbd_q   <= 1'b0;
    end else begin
      redir_q <= (sel_i != ENTRY_NONE);
      unique case (sel_i)
        ENTRY_NMI: begin
          tgt_q   <= RESET_VEC;
          errpc_q <= ret_i;
          stat_q  <= STAT_NMI;
        end
        ENTRY_DBG: begin
          tgt_q <= DEBUG_VEC;
          dpc_q <= ret_i;
          dbd_q <= in_delay_i;
        end
        default: begin
          if (stat_ld_i) stat_q <= stat_d_i;
        end
      endcase
    end
  end

  assign redirect_o = redir_q;
  assign target_o   = tgt_q;
  assign status_o   = stat_q;
  assign errpc_o    = errpc_q;
  assign dpc_o      = dpc_q;
  assign dbd_o      = dbd_q;

  // R5: NMI entry redirects to the reset vector
  assert_nmi_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == ENTRY_NMI) |=> (redirect_o && target_o == RESET_VEC));

  // R3: fixed status pattern after NMI entry
  assert_nmi_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == ENTRY_NMI) |=> (status_o == STAT_NMI));

  // R4: delay-slot resume address
  assert_errpc_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == ENTRY_NMI && in_delay_i) |=> (errpc_o == $past(pc_i) - STEP));

  // R8: debug resume address and slot flag
  assert_dpc_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == ENTRY_DBG) |=> (dbd_o == $past(in_delay_i) &&
      dpc_o == (dbd_o ? $past(pc_i) - STEP : $past(pc_i))));

  // R11: debug entry leaves NMI state alone
  assert_dbg_keeps_errpc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == ENTRY_DBG) |=> ($stable(errpc_o) && $stable(status_o)));

  // R11: NMI entry leaves debug state alone
  assert_nmi_keeps_dpc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == ENTRY_NMI) |=> ($stable(dpc_o) && $stable(dbd_o)));

endmodule

// File: rtl/async_trap_entry.sv
module async_trap_entry
  import async_trap_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter int unsigned     INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] DEBUG_VEC   = 32'hBFC0_0480
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            nmi_pin_i,
  input  logic            dbg_req_i,
  input  logic            brk_set_i,
  input  logic            dret_i,
  input  logic            boundary_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_delay_i,
  input  logic            stat_ld_i,
  input  logic [4:0]      stat_d_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic [4:0]      status_o,
  output logic [XLEN-1:0] errpc_o,
  output logic [XLEN-1:0] dpc_o,
  output logic            dint_o,
  output logic            dbd_o,
  output logic            dbg_mode_o,
  output logic            brk_o
);
  entry_e          sel;
  logic            nmi_pend, dbg_want;
  logic [XLEN-1:0] ret_addr;
  stat_t           stat_in, stat_out;

  assign stat_in  = stat_t'(stat_d_i);
  assign status_o = stat_out;

  trap_nmi_capture #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (nmi_pin_i),
    .clr_i  (sel == ENTRY_NMI),
    .pend_o (nmi_pend)
  );

  trap_dbg_track u_dbg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (dbg_req_i),
    .brk_set_i (brk_set_i),
    .take_i    (sel == ENTRY_DBG),
    .dret_i    (dret_i),
    .want_o    (dbg_want),
    .mode_o    (dbg_mode_o),
    .brk_o     (brk_o),
    .dint_o    (dint_o)
  );

  trap_return_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ret (
    .pc_i       (pc_i),
    .in_delay_i (in_delay_i),
    .ret_o      (ret_addr)
  );

  trap_entry_arb u_arb (
    .dbg_want_i (dbg_want),
    .nmi_pend_i (nmi_pend),
    .boundary_i (boundary_i),
    .sel_o      (sel)
  );

  trap_entry_regs #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES),
    .RESET_VEC  (RESET_VEC),
    .DEBUG_VEC  (DEBUG_VEC)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .ret_i      (ret_addr),
    .pc_i       (pc_i),
    .in_delay_i (in_delay_i),
    .stat_ld_i  (stat_ld_i),
    .stat_d_i   (stat_in),
    .redirect_o (redirect_o),
    .target_o   (target_o),
    .status_o   (stat_out),
    .errpc_o    (errpc_o),
    .dpc_o      (dpc_o),
    .dbd_o      (dbd_o)
  );

  // R2: an NMI redirect always follows a boundary cycle
  assert_nmi_at_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && target_o == RESET_VEC) |-> $past(boundary_i));

  // R9: debug request outranks a pending NMI
  assert_dbg_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_want && nmi_pend && boundary_i) |=> (target_o == DEBUG_VEC && $stable(errpc_o)));

endmodule

// File: tb/async_trap_entry_tb_top.sv
`timescale 1ns/1ps
module async_trap_entry_tb_top;
  localparam logic [31:0] RVEC = 32'hBFC0_0000;
  localparam logic [31:0] DVEC = 32'hBFC0_0480;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 0, dbg_req = 0, brk_set = 0, dret = 0, boundary = 0;
  logic [31:0] pc = '0;
  logic        in_delay = 0, stat_ld = 0;
  logic [4:0]  stat_d = '0;
  logic        redirect, dint, dbd, dbg_mode, brk;
  logic [31:0] target, errpc, dpc;
  logic [4:0]  status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  async_trap_entry dut_i (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pin_i(nmi_pin), .dbg_req_i(dbg_req),
    .brk_set_i(brk_set), .dret_i(dret), .boundary_i(boundary), .pc_i(pc),
    .in_delay_i(in_delay), .stat_ld_i(stat_ld), .stat_d_i(stat_d),
    .redirect_o(redirect), .target_o(target), .status_o(status),
    .errpc_o(errpc), .dpc_o(dpc), .dint_o(dint), .dbd_o(dbd),
    .dbg_mode_o(dbg_mode), .brk_o(brk)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_redirects(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (redirect) cnt++;
    end
  endtask

  task automatic t_reset;
    chk("R12", "redirect", 32'(redirect), 0);
    chk("R12", "status", 32'(status), 32'h11);
    chk("R12", "errpc", errpc, 0);
    chk("R12", "dpc", dpc, 0);
    chk("R12", "dbg bits", {28'd0, dint, dbd, dbg_mode, brk}, 0);
  endtask

  task automatic t_status_load;
    stat_d = 5'b01100; stat_ld = 1;
    tick(1);
    stat_ld = 0;
    chk("R3", "status load", 32'(status), 32'h0C);
  endtask

  task automatic t_nmi_boundary;
    int cnt;
    pc = 32'h0000_1000; in_delay = 0; boundary = 0;
    nmi_pin = 1;
    count_redirects(8, cnt);
    chk("R2", "no entry without boundary", 32'(cnt), 0);
    chk("R2", "errpc untouched while pending", errpc, 0);
    boundary = 1;
    tick(1);
    boundary = 0;
    chk("R2", "redirect after boundary", 32'(redirect), 1);
    chk("R5", "nmi target", target, RVEC);
    chk("R4", "errpc plain", errpc, 32'h0000_1000);
    chk("R3", "nmi status", 32'(status), 32'h13);
    chk("R11", "dpc kept", dpc, 0);
    chk("R11", "dint kept", 32'(dint), 0);
    tick(1);
    chk("R5", "strobe one cycle", 32'(redirect), 0);
    boundary = 1;
    count_redirects(10, cnt);
    chk("R1", "held pin gives no second entry", 32'(cnt), 0);
    boundary = 0; nmi_pin = 0;
    tick(4);
  endtask

  task automatic t_nmi_delay;
    int cnt;
    pc = 32'h0000_2008; in_delay = 1; boundary = 1;
    nmi_pin = 1;
    count_redirects(8, cnt);
    chk("R1", "one entry per edge", 32'(cnt), 1);
    chk("R4", "errpc delay slot", errpc, 32'h0000_2004);
    boundary = 0; nmi_pin = 0; in_delay = 0;
    tick(4);
  endtask

  task automatic t_dbg_req;
    int cnt;
    pc = 32'h0000_3010; in_delay = 1; boundary = 0;
    dbg_req = 1;
    tick(1);
    chk("R7", "debug redirect without boundary", 32'(redirect), 1);
    chk("R7", "debug target", target, DVEC);
    chk("R7", "dint and mode", {30'd0, dint, dbg_mode}, 32'h3);
    chk("R8", "dpc delay slot", dpc, 32'h0000_300C);
    chk("R8", "dbd set", 32'(dbd), 1);
    chk("R11", "errpc kept", errpc, 32'h0000_2004);
    chk("R11", "status kept", 32'(status), 32'h13);
    count_redirects(4, cnt);
    chk("R10", "no reentry in debug mode", 32'(cnt), 0);
    dbg_req = 0; in_delay = 0;
    dret = 1;
    tick(1);
    dret = 0;
    chk("R10", "dret clears mode and dint", {30'd0, dint, dbg_mode}, 0);
  endtask

  task automatic t_brk;
    int cnt;
    pc = 32'h0000_4000; in_delay = 0;
    brk_set = 1;
    tick(1);
    brk_set = 0;
    chk("R6", "break bit visible", 32'(brk), 1);
    tick(1);
    chk("R6", "break entry", 32'(redirect), 1);
    chk("R8", "dpc plain", dpc, 32'h0000_4000);
    chk("R8", "dbd clear", 32'(dbd), 0);
    chk("R6", "break bit cleared", 32'(brk), 0);
    brk_set = 1;
    tick(1);
    brk_set = 0;
    count_redirects(4, cnt);
    chk("R10", "break held off in debug mode", 32'(cnt), 0);
    chk("R10", "break bit held", 32'(brk), 1);
    dret = 1;
    tick(1);
    dret = 0;
    chk("R10", "mode cleared", 32'(dbg_mode), 0);
    tick(1);
    chk("R6", "held break taken after dret", 32'(redirect), 1);
    chk("R6", "break bit cleared again", 32'(brk), 0);
    dret = 1;
    tick(1);
    dret = 0;
    tick(1);
  endtask

  task automatic t_priority;
    int cnt;
    nmi_pin = 1; boundary = 0;
    tick(6);
    pc = 32'h0000_5000; in_delay = 0;
    dbg_req = 1; boundary = 1;
    tick(1);
    dbg_req = 0; boundary = 0;
    chk("R9", "debug wins", target, DVEC);
    chk("R9", "errpc untouched", errpc, 32'h0000_2004);
    count_redirects(3, cnt);
    chk("R9", "nmi waits", 32'(cnt), 0);
    pc = 32'h0000_5004;
    boundary = 1;
    tick(1);
    boundary = 0;
    chk("R9", "nmi served later", target, RVEC);
    chk("R9", "nmi errpc", errpc, 32'h0000_5004);
    chk("R11", "dpc kept after nmi", dpc, 32'h0000_5000);
    nmi_pin = 0;
    dret = 1;
    tick(1);
    dret = 0;
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1;
    tick(1);
    t_status_load();
    t_nmi_boundary();
    t_nmi_delay();
    t_dbg_req();
    t_brk();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule